// File: doc/BRIEF.md
# Triangle Vertex Fetch Assembler

This block builds the triangle stream for a single draw command. It reads vertex records from memory and packs each group of three into one triangle on a valid/ready output. Two fetch modes are supported. In direct mode the block walks the vertex buffer by consecutive vertex numbers. In gather mode it first reads a vertex number from an index list, then fetches the record that number selects. A list may name the same vertex more than once.

A command carries the mode, a start offset, a count, two base word addresses (index list and vertex buffer) and an attribute count. The command is taken only while the block is idle. Each attribute is one memory word. The read port is synchronous: data for a request appears on the read-data input in the cycle after the request.

A count that is not a multiple of three loses its trailing one or two vertices. A single `done` pulse closes every command.

Top module: `tfa_top`

## Requirements
- R1: In direct mode, vertex v of a command (v = 0, 1, ...) is vertex number start+v. Attribute a of vertex number n is read from word address vtx_base + n*A + a, where A is the effective attribute count. Each request's data is taken from `mem_rdata` one cycle after `mem_req`.
- R2: In gather mode, the number of vertex v is the low IDX_W bits of the word read from idx_base + start + v. This index read is issued before that vertex's attribute reads. Repeated index values fetch the same record again.
- R3: Each three fetched vertices form one triangle. The first fetched vertex is corner 0. Corner k, attribute a occupies `tri_data` bits starting at (k*MAX_ATTR + a)*ATTR_W.
- R4: The effective attribute count A is 1 when the command field is 0, MAX_ATTR when the field exceeds MAX_ATTR, and the field value otherwise. Slots with a >= A read as zero. MAX_ATTR must lie between 1 and 32.
- R5: A command with count c emits exactly floor(c/3) triangles. The remaining c mod 3 vertices are never fetched.
- R6: While `tri_valid` is high and `tri_ready` is low, `mem_req` stays low and `tri_data` holds its value.
- R7: `cmd_ready` is high only while the block is idle. A command presented while `cmd_ready` is low has no effect on the triangles produced.
- R8: `done` is high for exactly one cycle. That cycle is the one after the last triangle handshake, or the one after command acceptance when the command yields no triangle.
- R9: After reset, `cmd_ready` is high and `tri_valid`, `done` and `mem_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block idle, command taken this cycle if valid |
| cmd_indexed | input | 1 | 1 = gather mode, 0 = direct mode |
| cmd_start | input | IDX_W | Start vertex number or index-list offset |
| cmd_count | input | CNT_W | Vertex or index count |
| cmd_idx_base | input | ADDR_W | Word address of the index list |
| cmd_vtx_base | input | ADDR_W | Word address of the vertex buffer |
| cmd_attr_cnt | input | $clog2(MAX_ATTR)+1 | Attributes per vertex (clamped) |
| mem_req | output | 1 | Read request |
| mem_addr | output | ADDR_W | Read word address |
| mem_rdata | input | ATTR_W | Read data, one cycle after request |
| tri_valid | output | 1 | Triangle available |
| tri_ready | input | 1 | Downstream accepts triangle |
| tri_data | output | 3*MAX_ATTR*ATTR_W | Packed triangle |
| done | output | 1 | One-cycle end-of-command pulse |

## Verification
The bench builds the block with MAX_ATTR=3, ATTR_W=16, ADDR_W=8, IDX_W=8 and CNT_W=6. With a three-bit attribute-count field, a request of 6 can be driven, so clamping is exercised both above and below the legal range. A three-slot vertex also leaves slots that must stay zero when only one or two attributes are used. The small address space lets the bench model the whole memory as a function of address, with the index list placed in the top quarter. Gather lists with repeats, counts with remainders of one and two, a zero-triangle count and a thin ready pattern then fit in a few thousand cycles.

// File: rtl/tfa_pkg.sv
package tfa_pkg;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_IDX   = 3'd1,
    S_IWAIT = 3'd2,
    S_VTX   = 3'd3,
    S_HOLD  = 3'd4
  } tfa_state_e;

  // clamp a requested attribute count into 1..maxa
  function automatic logic [31:0] eff_attr(input logic [31:0] req, input logic [31:0] maxa);
    if (req == 32'd0) return 32'd1;
    if (req > maxa)   return maxa;
    return req;
  endfunction

  // vertices that end up in whole triangles
  function automatic logic [31:0] kept_verts(input logic [31:0] cnt);
    return (cnt / 32'd3) * 32'd3;
  endfunction

  function automatic logic [31:0] idx_word(input logic [31:0] base, input logic [31:0] start,
                                           input logic [31:0] v);
    return base + start + v;
  endfunction

  function automatic logic [31:0] vtx_word(input logic [31:0] base, input logic [31:0] vnum,
                                           input logic [31:0] acnt, input logic [31:0] a);
    return base + vnum * acnt + a;
  endfunction

endpackage

// File: rtl/tfa_seq.sv
module tfa_seq
  import tfa_pkg::*;
#(
  parameter int IDX_W    = 12,
  parameter int CNT_W    = 12,
  parameter int ADDR_W   = 16,
  parameter int ATTR_W   = 32,
  parameter int MAX_ATTR = 4,
  parameter int AIDX_W   = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cmd_valid,
  output logic                  cmd_ready,
  input  logic                  cmd_indexed,
  input  logic [IDX_W-1:0]      cmd_start,
  input  logic [CNT_W-1:0]      cmd_count,
  input  logic [ADDR_W-1:0]     cmd_idx_base,
  input  logic [ADDR_W-1:0]     cmd_vtx_base,
  input  logic [AIDX_W:0]       cmd_attr_cnt,
  output logic                  mem_req,
  output logic [ADDR_W-1:0]     mem_addr,
  input  logic [ATTR_W-1:0]     mem_rdata,
  input  logic                  tri_valid,
  input  logic                  tri_ready,
  output logic                  wr_en,
  output logic [1:0]            wr_k,
  output logic [AIDX_W-1:0]     wr_a,
  output logic                  wr_last,
  output logic                  done
);

  tfa_state_e          st;
  logic                ind_r;
  logic [IDX_W-1:0]    start_r;
  logic [ADDR_W-1:0]   ibase_r;
  logic [ADDR_W-1:0]   vbase_r;
  logic [AIDX_W:0]     acnt_r;
  logic [CNT_W-1:0]    nv_r;
  logic [CNT_W-1:0]    vcnt_r;
  logic [1:0]          k_r;
  logic [AIDX_W-1:0]   a_r;
  logic [IDX_W-1:0]    cur_r;

  // named internal events
  logic issue_idx, issue_vtx, vtx_end, tri_end, out_hs, cmd_take, last_tri;
  logic [31:0] nv_calc, acnt_calc, iaddr, vaddr;

  assign issue_idx = (st == S_IDX);
  assign issue_vtx = (st == S_VTX);
  assign vtx_end   = issue_vtx && ((AIDX_W+1)'(a_r) == acnt_r - 1'b1);
  assign tri_end   = vtx_end && (k_r == 2'd2);
  assign out_hs    = tri_valid && tri_ready;
  assign cmd_take  = cmd_valid && (st == S_IDLE);
  assign last_tri  = (vcnt_r == nv_r);
  assign cmd_ready = (st == S_IDLE);

  assign nv_calc   = kept_verts(32'(cmd_count));
  assign acnt_calc = eff_attr(32'(cmd_attr_cnt), 32'(MAX_ATTR));
  assign iaddr     = idx_word(32'(ibase_r), 32'(start_r), 32'(vcnt_r));
  assign vaddr     = vtx_word(32'(vbase_r), 32'(cur_r), 32'(acnt_r), 32'(a_r));

  assign mem_req  = issue_idx || issue_vtx;
  assign mem_addr = issue_idx ? iaddr[ADDR_W-1:0] : vaddr[ADDR_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      ind_r   <= 1'b0;
      start_r <= '0;
      ibase_r <= '0;
      vbase_r <= '0;
      acnt_r  <= '0;
      nv_r    <= '0;
      vcnt_r  <= '0;
      k_r     <= '0;
      a_r     <= '0;
      cur_r   <= '0;
      wr_en   <= 1'b0;
      wr_k    <= '0;
      wr_a    <= '0;
      wr_last <= 1'b0;
      done    <= 1'b0;
    end else begin
      done    <= 1'b0;
      wr_en   <= issue_vtx;
      wr_k    <= k_r;
      wr_a    <= a_r;
      wr_last <= tri_end;
      case (st)
        S_IDLE: begin
          if (cmd_take) begin
            ind_r   <= cmd_indexed;
            start_r <= cmd_start;
            ibase_r <= cmd_idx_base;
            vbase_r <= cmd_vtx_base;
            acnt_r  <= acnt_calc[AIDX_W:0];
            nv_r    <= nv_calc[CNT_W-1:0];
            vcnt_r  <= '0;
            k_r     <= '0;
            a_r     <= '0;
            cur_r   <= cmd_start;
            if (nv_calc == 32'd0) done <= 1'b1;
            else st <= cmd_indexed ? S_IDX : S_VTX;
          end
        end
        S_IDX:   st <= S_IWAIT;
        S_IWAIT: begin
          cur_r <= mem_rdata[IDX_W-1:0];
          st    <= S_VTX;
        end
        S_VTX: begin
          if (vtx_end) begin
            a_r    <= '0;
            vcnt_r <= vcnt_r + 1'b1;
            cur_r  <= cur_r + 1'b1;
            if (k_r == 2'd2) begin
              k_r <= '0;
              st  <= S_HOLD;
            end else begin
              k_r <= k_r + 1'b1;
              st  <= ind_r ? S_IDX : S_VTX;
            end
          end else begin
            a_r <= a_r + 1'b1;
          end
        end
        S_HOLD: begin
          if (!wr_en && out_hs) begin
            if (last_tri) begin
              st   <= S_IDLE;
              done <= 1'b1;
            end else begin
              st <= ind_r ? S_IDX : S_VTX;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/tfa_pack.sv
module tfa_pack #(
  parameter int MAX_ATTR = 4,
  parameter int ATTR_W   = 32,
  parameter int AIDX_W   = 2,
  localparam int TRI_W   = 3 * MAX_ATTR * ATTR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_k,
  input  logic [AIDX_W-1:0] wr_a,
  input  logic              wr_last,
  input  logic [ATTR_W-1:0] wr_data,
  input  logic              tri_ready,
  output logic              tri_valid,
  output logic [TRI_W-1:0]  tri_data
);

  logic [ATTR_W-1:0] slot [0:2][0:MAX_ATTR-1];
  logic              take;

  assign take = tri_valid && tri_ready;

  always_ff @(posedge clk) begin
    if (!rst_n || take) begin
      tri_valid <= 1'b0;
      for (int k = 0; k < 3; k++)
        for (int a = 0; a < MAX_ATTR; a++)
          slot[k][a] <= '0;
    end else if (wr_en) begin
      slot[wr_k][wr_a] <= wr_data;
      if (wr_last) tri_valid <= 1'b1;
    end
  end

  for (genvar gk = 0; gk < 3; gk++) begin : g_corner
    for (genvar ga = 0; ga < MAX_ATTR; ga++) begin : g_attr
      assign tri_data[(gk*MAX_ATTR+ga)*ATTR_W +: ATTR_W] = slot[gk][ga];
    end
  end

endmodule

// File: rtl/tfa_top.sv
module tfa_top #(
  parameter int IDX_W    = 12,
  parameter int CNT_W    = 12,
  parameter int ADDR_W   = 16,
  parameter int ATTR_W   = 32,
  parameter int MAX_ATTR = 4
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              cmd_valid,
  output logic                              cmd_ready,
  input  logic                              cmd_indexed,
  input  logic [IDX_W-1:0]                  cmd_start,
  input  logic [CNT_W-1:0]                  cmd_count,
  input  logic [ADDR_W-1:0]                 cmd_idx_base,
  input  logic [ADDR_W-1:0]                 cmd_vtx_base,
  input  logic [$clog2(MAX_ATTR):0]         cmd_attr_cnt,
  output logic                              mem_req,
  output logic [ADDR_W-1:0]                 mem_addr,
  input  logic [ATTR_W-1:0]                 mem_rdata,
  output logic                              tri_valid,
  input  logic                              tri_ready,
  output logic [3*MAX_ATTR*ATTR_W-1:0]      tri_data,
  output logic                              done
);

  localparam int AIDX_W = (MAX_ATTR > 1) ? $clog2(MAX_ATTR) : 1;

  if (MAX_ATTR < 1 || MAX_ATTR > 32) begin : g_bad_attr
    $error("MAX_ATTR must be within 1..32");
  end
  if (ATTR_W < IDX_W) begin : g_bad_width
    $error("ATTR_W must hold an index");
  end

  logic              wr_en, wr_last;
  logic [1:0]        wr_k;
  logic [AIDX_W-1:0] wr_a;
  logic [AIDX_W:0]   acnt_in;

  assign acnt_in = (AIDX_W+1)'(cmd_attr_cnt);

  tfa_seq #(
    .IDX_W(IDX_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W),
    .ATTR_W(ATTR_W), .MAX_ATTR(MAX_ATTR), .AIDX_W(AIDX_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_indexed(cmd_indexed),
    .cmd_start(cmd_start), .cmd_count(cmd_count),
    .cmd_idx_base(cmd_idx_base), .cmd_vtx_base(cmd_vtx_base),
    .cmd_attr_cnt(acnt_in),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .tri_valid(tri_valid), .tri_ready(tri_ready),
    .wr_en(wr_en), .wr_k(wr_k), .wr_a(wr_a), .wr_last(wr_last),
    .done(done)
  );

  tfa_pack #(
    .MAX_ATTR(MAX_ATTR), .ATTR_W(ATTR_W), .AIDX_W(AIDX_W)
  ) u_pack (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_k(wr_k), .wr_a(wr_a), .wr_last(wr_last),
    .wr_data(mem_rdata), .tri_ready(tri_ready),
    .tri_valid(tri_valid), .tri_data(tri_data)
  );

endmodule

// File: rtl/tfa_checker.sv
module tfa_checker #(
  parameter int TRI_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic             mem_req,
  input logic             tri_valid,
  input logic             tri_ready,
  input logic [TRI_W-1:0] tri_data,
  input logic             done
);

  AST_STALL_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    tri_valid && !tri_ready |-> !mem_req); // R6

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    tri_valid && !tri_ready |=> tri_valid && $stable(tri_data)); // R6

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !tri_valid && !mem_req); // R7

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8

  AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(tri_valid && tri_ready) || $past(cmd_valid && cmd_ready)); // R8

endmodule

bind tfa_top tfa_checker #(.TRI_W(3*MAX_ATTR*ATTR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .mem_req(mem_req), .tri_valid(tri_valid), .tri_ready(tri_ready),
  .tri_data(tri_data), .done(done)
);

// File: tb/tfa_top_bench.sv
module tfa_top_bench;

  localparam int IDX_W = 8, CNT_W = 6, ADDR_W = 8, ATTR_W = 16, MAX_ATTR = 3;
  localparam int TRI_W = 3 * MAX_ATTR * ATTR_W;
  localparam int LIST0 = 192;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_indexed = 1'b0, tri_ready = 1'b0;
  logic [IDX_W-1:0]  cmd_start = '0;
  logic [CNT_W-1:0]  cmd_count = '0;
  logic [ADDR_W-1:0] cmd_idx_base = '0, cmd_vtx_base = '0;
  logic [2:0]        cmd_attr_cnt = '0;
  logic cmd_ready, mem_req, tri_valid, done;
  logic [ADDR_W-1:0] mem_addr;
  logic [ATTR_W-1:0] mem_rdata = '0;
  logic [TRI_W-1:0]  tri_data;

  logic [15:0] ilist [0:63];
  int total = 0, bad = 0, cycles = 0;

  always #2.5 clk = ~clk;

  tfa_top #(.IDX_W(IDX_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .ATTR_W(ATTR_W),
            .MAX_ATTR(MAX_ATTR)) u_tfa_top (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_indexed(cmd_indexed), .cmd_start(cmd_start), .cmd_count(cmd_count),
    .cmd_idx_base(cmd_idx_base), .cmd_vtx_base(cmd_vtx_base),
    .cmd_attr_cnt(cmd_attr_cnt), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .tri_valid(tri_valid), .tri_ready(tri_ready),
    .tri_data(tri_data), .done(done));

  // memory content as a function of address; index list in the top quarter
  function automatic logic [15:0] mem_word(input logic [7:0] addr);
    if (int'(addr) >= LIST0) return ilist[int'(addr) - LIST0];
    return {addr ^ 8'hA5, addr};
  endfunction

  always @(posedge clk) if (mem_req) mem_rdata <= mem_word(mem_addr);

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      bad = bad + 1; total = total + 1;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected < 150000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input logic [TRI_W-1:0] act,
                       input logic [TRI_W-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [TRI_W-1:0] exp_tri(input bit ind, input int st, input int ib,
                                               input int vb, input int eac, input int t);
    logic [TRI_W-1:0] r = '0;
    for (int k = 0; k < 3; k++) begin
      int v = t * 3 + k;
      int n = ind ? int'(mem_word(8'(ib + st + v)) & 16'h00FF) : ((st + v) & 255);
      for (int a = 0; a < MAX_ATTR; a++)
        if (a < eac) r[(k*MAX_ATTR+a)*ATTR_W +: ATTR_W] = mem_word(8'(vb + n * eac + a));
    end
    return r;
  endfunction

  // one command; stall thins ready, poke drives a second command while busy
  task automatic run_cmd(input string req, input bit ind, input int st, input int cnt,
                         input int ib, input int vb, input int ac, input bit stall,
                         input bit poke);
    int ntri = cnt / 3;
    int eac = (ac == 0) ? 1 : (ac > MAX_ATTR ? MAX_ATTR : ac);
    int got = 0, cyc = 0;
    bit exp_done = (ntri == 0), seen = 0, rd_in_stall = 0;
    @(negedge clk);
    check(cmd_ready == 1'b1, {req, " R7 idle before command"}, TRI_W'(cmd_ready), 1);
    cmd_valid = 1'b1; cmd_indexed = ind; cmd_start = 8'(st); cmd_count = 6'(cnt);
    cmd_idx_base = 8'(ib); cmd_vtx_base = 8'(vb); cmd_attr_cnt = 3'(ac);
    tri_ready = 1'b0;
    while (!seen && cyc < 4000) begin
      @(negedge clk);
      cyc++;
      if (poke && ntri > 0 && !exp_done) begin
        cmd_valid = 1'b1; cmd_indexed = ~ind; cmd_start = 8'(st + 5);
        cmd_count = 6'd3; cmd_vtx_base = 8'(vb + 40); cmd_attr_cnt = 3'd1;
      end else cmd_valid = 1'b0;
      if (done) begin
        seen = 1;
        cmd_valid = 1'b0;
        check(exp_done, {req, " R8 done timing"}, TRI_W'(got), TRI_W'(ntri));
      end else if (exp_done) begin
        check(1'b0, {req, " R8 done missing"}, 0, 1);
      end
      if (cyc == 3 && ntri > 0)
        check(cmd_ready == 1'b0, {req, " R7 busy"}, TRI_W'(cmd_ready), 0);
      tri_ready = stall ? ((cyc % 7) == 0) : 1'b1;
      if (tri_valid && !tri_ready && mem_req) rd_in_stall = 1;
      exp_done = 0;
      if (tri_valid && tri_ready && !seen) begin
        logic [TRI_W-1:0] e = exp_tri(ind, st, ib, vb, eac, got);
        check(tri_data == e, {req, " R3 triangle"}, tri_data, e);
        got++;
        if (got == ntri) exp_done = 1;
      end
    end
    cmd_valid = 1'b0;
    tri_ready = 1'b0;
    check(seen && got == ntri, {req, " R5 triangle count"}, TRI_W'(got), TRI_W'(ntri));
    if (stall) check(!rd_in_stall, {req, " R6 read while stalled"}, TRI_W'(rd_in_stall), 0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(cmd_ready && !tri_valid && !done && !mem_req, "R9 reset state",
          TRI_W'({cmd_ready, tri_valid, done, mem_req}), TRI_W'(4'b1000));
  endtask

  initial begin
    for (int i = 0; i < 64; i++) ilist[i] = 16'h7700 | 16'((i * 5 + 3) % 23);
    ilist[2] = 16'h0005; ilist[3] = 16'h1101; ilist[4] = 16'h0005;
    ilist[5] = 16'h0000; ilist[6] = 16'h2207; ilist[7] = 16'h0007;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    run_cmd("R1 direct a2", 0, 4, 6, LIST0, 16, 2, 0, 0);
    run_cmd("R1 direct a3", 0, 0, 9, LIST0, 64, 3, 0, 0);
    run_cmd("R2 gather repeats", 1, 2, 6, LIST0, 32, 3, 0, 0);
    run_cmd("R5 count 7", 0, 1, 7, LIST0, 8, 1, 0, 0);
    run_cmd("R5 R8 count 2", 0, 1, 2, LIST0, 8, 2, 0, 0);
    run_cmd("R4 attr 0", 1, 10, 3, LIST0, 50, 0, 0, 0);
    run_cmd("R4 attr 6", 0, 7, 5, LIST0, 20, 6, 0, 0);
    run_cmd("R6 stall gather", 1, 20, 9, LIST0, 4, 2, 1, 0);
    run_cmd("R7 poke while busy", 0, 3, 6, LIST0, 12, 3, 0, 1);
    t_reset();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule